// File: doc/BRIEF.md
# Dual Timer Output Combiner

This block drives one output pin of an infrared carrier generator from two down-counting timers. Timer A is narrow and timer B is wide. Each timer toggles its own output line at its terminal count and then reloads from a programmed reload value. A boolean function merges the two lines, or a plain general-purpose level goes to the pin instead. When a timer is not enabled, its line rests at the opposite of a programmed start level. The first clock edge with the enable high sets the line to the start level, so every start gives a visible edge.

An eight-bit configuration word sets the operating mode, the pin source, the merge function, the start levels and a sub-mode. In the normal sub-mode the two timers run independently. In the alternating sub-mode the timer A enable starts a chain in which the two timers take turns. The two forcing codes hold the timer B line at a constant. Selecting the receive mode parks both timers, and the pin then carries the general-purpose level.

Top module: `dual_tmr_combiner`

## Requirements
- R1: After reset the configuration word is zero, both reload values are zero, both timer lines are 1 and the pin follows `gpo_i`.
- R2: When configuration bit 6 (pin select) is 0, the pin equals `gpo_i` whatever the timers do. When it is 1 in transmit mode, the pin carries the merged line.
- R3: The merge function sits in configuration bits 5:4: 00 gives A AND B, 01 gives A OR B, 10 gives NOR, 11 gives NAND.
- R4: A timer line that is not enabled rests at the inverse of its start level (bit 1 for A, bit 0 for B). On the first clock edge that sees the enable high, the line takes the start level and the counter loads its reload value.
- R5: In the normal sub-mode (bits 3:2 = 00), a running timer with reload value N toggles its line every N+1 cycles.
- R6: In the alternating sub-mode (bits 3:2 = 01), the timer A enable starts A. When A reaches terminal count it toggles and stops, and B starts. On its first turn B's line takes its start level; on later turns B holds its level until its own terminal count toggles it. B's terminal count restarts A. The timer B enable is ignored.
- R7: Writing sub-mode 00 during alternating operation ends it. From the next edge, timer B follows its own enable and timer A keeps counting on its own.
- R8: Sub-mode 10 drives the timer B line to 0 and sub-mode 11 drives it to 1, from the edge that stores the code. The timer B enable has no effect while a forcing code is set.
- R9: A write to a start-level bit is dropped while that timer is busy. For timer B, busy also covers a running alternating chain. Other configuration fields are still written.
- R10: When configuration bit 7 is 1 (receive mode), both timers stay parked at their resting levels and the pin equals `gpo_i`.
- R11: The reload values are written through their own write strobes. A value written while a timer is idle takes effect when that timer next starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| a_rld_we_i | input | 1 | Timer A reload write strobe |
| a_rld_i | input | A_W | Timer A reload value |
| b_rld_we_i | input | 1 | Timer B reload write strobe |
| b_rld_i | input | B_W | Timer B reload value |
| a_en_i | input | 1 | Timer A enable (starts the chain in the alternating sub-mode) |
| b_en_i | input | 1 | Timer B enable (normal sub-mode only) |
| gpo_i | input | 1 | General-purpose pin level |
| a_out_o | output | 1 | Timer A line |
| b_out_o | output | 1 | Timer B line, after forcing |
| pin_o | output | 1 | Output pin |

## Verification
The hardest situation to reach from the ports is leaving the alternating sub-mode in the middle of a turn while the timer B enable is held high. At that point both timers must switch to independent operation on the same edge. The stimulus uses reload values of 2 and 1, so the alternating chain runs through two full handovers in about ten cycles. Throughout the chain, the timer B enable is held high to show that it is ignored. The normal code is then written while A is mid-count. The check lands on the cycle where B toggles under normal operation but would still be holding under alternation.

// File: rtl/tmr_comb_pkg.sv
package tmr_comb_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOR  = 2'b10,
    FN_NAND = 2'b11
  } comb_fn_e;

  typedef enum logic [1:0] {
    SUB_NORM = 2'b00,
    SUB_ALT  = 2'b01,
    SUB_LOW  = 2'b10,
    SUB_HIGH = 2'b11
  } sub_e;

  typedef struct packed {
    logic     demod;
    logic     pin_sel;
    comb_fn_e fn;
    sub_e     sub;
    logic     lvl_a;
    logic     lvl_b;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] rld_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= rld_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  assign tc_o = (cnt_q == '0);

  // R5: terminal count reloads, never wraps
  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_comb_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             busy_a_i,
  input  logic             busy_b_i,
  input  logic             a_rld_we_i,
  input  logic [A_W-1:0]   a_rld_i,
  input  logic             b_rld_we_i,
  input  logic [B_W-1:0]   b_rld_i,
  output cfg_t             cfg_o,
  output logic [A_W-1:0]   a_rld_o,
  output logic [B_W-1:0]   b_rld_o
);
  cfg_t cfg_q, cfg_wr, cfg_nx;

  assign cfg_wr = cfg_t'(cfg_wdata_i);

  always_comb begin
    cfg_nx = cfg_wr;
    // start levels are locked while their timer is busy
    if (busy_a_i) cfg_nx.lvl_a = cfg_q.lvl_a;
    if (busy_b_i) cfg_nx.lvl_b = cfg_q.lvl_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         a_rld_o <= '0;
    else if (a_rld_we_i) a_rld_o <= a_rld_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         b_rld_o <= '0;
    else if (b_rld_we_i) b_rld_o <= b_rld_i;
  end

  assign cfg_o = cfg_q;

  a_r9_lvl_a_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_a_i |=> $stable(cfg_q.lvl_a));
  a_r9_lvl_b_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_b_i |=> $stable(cfg_q.lvl_b));
endmodule

// File: rtl/tmr_seq.sv
module tmr_seq
  import tmr_comb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       demod_i,
  input  logic [1:0] sub_i,
  input  logic       lvl_a_i,
  input  logic       lvl_b_i,
  input  logic       a_en_i,
  input  logic       b_en_i,
  input  logic       tc_a_i,
  input  logic       tc_b_i,
  output logic       ld_a_o,
  output logic       dec_a_o,
  output logic       ld_b_o,
  output logic       dec_b_o,
  output logic       busy_a_o,
  output logic       busy_b_o,
  output logic       a_out_o,
  output logic       b_out_o
);
  logic tx, alt, nrm, frc, en_a, en_b;
  logic run_a_q, run_b_q, phase_q, live_q, a_q, b_q;
  logic run_a_nx, run_b_nx, phase_nx, live_nx, a_nx, b_nx;

  assign tx   = !demod_i;
  assign alt  = tx && (sub_i == SUB_ALT);
  assign nrm  = tx && (sub_i == SUB_NORM);
  assign frc  = tx && sub_i[1];
  assign en_a = tx && a_en_i;
  assign en_b = nrm && b_en_i;

  always_comb begin
    ld_a_o = 1'b0; dec_a_o = 1'b0;
    ld_b_o = 1'b0; dec_b_o = 1'b0;
    run_a_nx = run_a_q; run_b_nx = run_b_q;
    phase_nx = phase_q; live_nx  = live_q;
    a_nx = a_q; b_nx = b_q;

    // timer A
    if (!en_a) begin
      run_a_nx = 1'b0; ld_a_o = 1'b1; a_nx = !lvl_a_i;
    end else if (!run_a_q) begin
      run_a_nx = 1'b1; ld_a_o = 1'b1; a_nx = lvl_a_i;
    end else if (!alt) begin
      if (tc_a_i) begin ld_a_o = 1'b1; a_nx = !a_q; end
      else dec_a_o = 1'b1;
    end else if (!phase_q) begin
      if (tc_a_i) begin
        a_nx = !a_q; phase_nx = 1'b1; ld_b_o = 1'b1;
        if (!live_q) begin b_nx = lvl_b_i; live_nx = 1'b1; end
      end else dec_a_o = 1'b1;
    end

    // timer B
    if (alt && en_a && run_a_q) begin
      run_b_nx = 1'b0;
      if (phase_q) begin
        if (tc_b_i) begin b_nx = !b_q; phase_nx = 1'b0; ld_a_o = 1'b1; end
        else dec_b_o = 1'b1;
      end
    end else begin
      phase_nx = 1'b0; live_nx = 1'b0;
      if (!en_b) begin
        run_b_nx = 1'b0; ld_b_o = 1'b1; b_nx = !lvl_b_i;
      end else if (!run_b_q) begin
        run_b_nx = 1'b1; ld_b_o = 1'b1; b_nx = lvl_b_i;
      end else if (tc_b_i) begin
        ld_b_o = 1'b1; b_nx = !b_q;
      end else dec_b_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_a_q <= 1'b0; run_b_q <= 1'b0;
      phase_q <= 1'b0; live_q  <= 1'b0;
      a_q <= 1'b1; b_q <= 1'b1;
    end else begin
      run_a_q <= run_a_nx; run_b_q <= run_b_nx;
      phase_q <= phase_nx; live_q  <= live_nx;
      a_q <= a_nx; b_q <= b_nx;
    end
  end

  assign busy_a_o = run_a_q;
  assign busy_b_o = run_b_q || (alt && run_a_q);
  assign a_out_o  = a_q;
  assign b_out_o  = frc ? sub_i[0] : b_q;

  a_r4_start_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a && !run_a_q) |=> (a_q == $past(lvl_a_i)));
  a_r10_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demod_i |=> (!run_a_q && !run_b_q));
  a_r8_forced_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc |=> !run_b_q);
  a_r6_one_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt |-> !(dec_a_o && dec_b_o));
endmodule

// File: rtl/tmr_pin_mux.sv
module tmr_pin_mux
  import tmr_comb_pkg::*;
(
  input  logic     demod_i,
  input  logic     pin_sel_i,
  input  comb_fn_e fn_i,
  input  logic     a_i,
  input  logic     b_i,
  input  logic     gpo_i,
  output logic     pin_o
);
  logic merged;

  always_comb begin
    unique case (fn_i)
      FN_AND:  merged = a_i & b_i;
      FN_OR:   merged = a_i | b_i;
      FN_NOR:  merged = !(a_i | b_i);
      FN_NAND: merged = !(a_i & b_i);
      default: merged = 1'b0;
    endcase
  end

  assign pin_o = (!demod_i && pin_sel_i) ? merged : gpo_i;
endmodule

// File: rtl/dual_tmr_combiner.sv
module dual_tmr_combiner
  import tmr_comb_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             a_rld_we_i,
  input  logic [A_W-1:0]   a_rld_i,
  input  logic             b_rld_we_i,
  input  logic [B_W-1:0]   b_rld_i,
  input  logic             a_en_i,
  input  logic             b_en_i,
  input  logic             gpo_i,
  output logic             a_out_o,
  output logic             b_out_o,
  output logic             pin_o
);
  cfg_t           cfg;
  logic [A_W-1:0] a_rld;
  logic [B_W-1:0] b_rld;
  logic busy_a, busy_b, ld_a, dec_a, ld_b, dec_b, tc_a, tc_b;

  tmr_cfg_regs #(.A_W(A_W), .B_W(B_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .busy_a_i(busy_a), .busy_b_i(busy_b),
    .a_rld_we_i(a_rld_we_i), .a_rld_i(a_rld_i),
    .b_rld_we_i(b_rld_we_i), .b_rld_i(b_rld_i),
    .cfg_o(cfg), .a_rld_o(a_rld), .b_rld_o(b_rld)
  );

  tmr_down_cnt #(.W(A_W)) u_cnt_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_a), .dec_i(dec_a),
    .rld_i(a_rld), .tc_o(tc_a)
  );

  tmr_down_cnt #(.W(B_W)) u_cnt_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_b), .dec_i(dec_b),
    .rld_i(b_rld), .tc_o(tc_b)
  );

  tmr_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .demod_i(cfg.demod), .sub_i(cfg.sub),
    .lvl_a_i(cfg.lvl_a), .lvl_b_i(cfg.lvl_b),
    .a_en_i(a_en_i), .b_en_i(b_en_i),
    .tc_a_i(tc_a), .tc_b_i(tc_b),
    .ld_a_o(ld_a), .dec_a_o(dec_a), .ld_b_o(ld_b), .dec_b_o(dec_b),
    .busy_a_o(busy_a), .busy_b_o(busy_b),
    .a_out_o(a_out_o), .b_out_o(b_out_o)
  );

  tmr_pin_mux u_mux (
    .demod_i(cfg.demod), .pin_sel_i(cfg.pin_sel), .fn_i(cfg.fn),
    .a_i(a_out_o), .b_i(b_out_o), .gpo_i(gpo_i), .pin_o(pin_o)
  );
endmodule

// File: tb/dual_tmr_combiner_test.sv
module dual_tmr_combiner_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, a_rld_we = 1'b0, b_rld_we = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_sh = '0;
  logic [7:0] a_rld = '0;
  logic [15:0] b_rld = '0;
  logic a_en = 1'b0, b_en = 1'b0, gpo = 1'b0;
  logic a_out, b_out, pin;

  dual_tmr_combiner uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .a_rld_we_i(a_rld_we), .a_rld_i(a_rld),
    .b_rld_we_i(b_rld_we), .b_rld_i(b_rld),
    .a_en_i(a_en), .b_en_i(b_en), .gpo_i(gpo),
    .a_out_o(a_out), .b_out_o(b_out), .pin_o(pin)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string tag_q[$];
  logic [2:0] exp_q[$];
  event chk_ev;

  // scoreboard monitor
  always @(chk_ev) begin
    while (exp_q.size() > 0) begin
      string t;
      logic [2:0] e, got;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      got = {a_out, b_out, pin};
      n_chk++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: a/b/pin actual=%b expected=%b", t, got, e);
      end
    end
  end

  function automatic logic exp_pin(logic a, logic b);
    if (cfg_sh[7] || !cfg_sh[6]) return gpo;
    case (cfg_sh[5:4])
      2'b00:   return a & b;
      2'b01:   return a | b;
      2'b10:   return !(a | b);
      default: return !(a & b);
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_cfg(logic [7:0] v);
    cfg_wdata = v; cfg_we = 1'b1; cfg_sh = v;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic wr_a(logic [7:0] v);
    a_rld = v; a_rld_we = 1'b1; step(1); a_rld_we = 1'b0;
  endtask

  task automatic wr_b(logic [15:0] v);
    b_rld = v; b_rld_we = 1'b1; step(1); b_rld_we = 1'b0;
  endtask

  task automatic check(string t, logic ea, logic eb);
    tag_q.push_back(t);
    exp_q.push_back({ea, eb, exp_pin(ea, eb)});
    -> chk_ev;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    check("R1 reset", 1'b1, 1'b1);
    gpo = 1'b1; #1;
    check("R2 gpo path", 1'b1, 1'b1);
    gpo = 1'b0; #1;

    // R3 merge functions, A=0 B=1 then A=1 B=1
    for (int f = 0; f < 4; f++) begin
      wr_cfg(8'h42 | 8'(f << 4)); step(1);
      check("R3 merge a0b1", 1'b0, 1'b1);
    end
    for (int f = 0; f < 4; f++) begin
      wr_cfg(8'h40 | 8'(f << 4)); step(1);
      check("R3 merge a1b1", 1'b1, 1'b1);
    end

    // R4 / R5 timer A normal, reload 3
    wr_a(8'd3);
    wr_cfg(8'h50); step(1);
    check("R4 idle", 1'b1, 1'b1);
    a_en = 1'b1; step(1);
    check("R4 start level", 1'b0, 1'b1);
    step(3); check("R5 hold", 1'b0, 1'b1);
    step(1); check("R5 toggle", 1'b1, 1'b1);
    step(4); check("R5 toggle 2", 1'b0, 1'b1);

    // R9 start-level write while busy is dropped
    wr_cfg(8'h52);
    a_en = 1'b0; step(1);
    check("R9 locked level", 1'b1, 1'b1);
    wr_cfg(8'h52); step(1);
    check("R9 idle write", 1'b0, 1'b1);

    // R11 new reload used at next start
    wr_a(8'd1);
    a_en = 1'b1; step(1);
    check("R11 start", 1'b1, 1'b1);
    step(1); check("R11 hold", 1'b1, 1'b1);
    step(1); check("R11 toggle", 1'b0, 1'b1);
    step(2); check("R11 toggle 2", 1'b1, 1'b1);
    a_en = 1'b0; step(1);

    // R4 / R5 timer B normal, reload 2, start level 1
    wr_b(16'd2);
    wr_cfg(8'h51); step(1);
    check("R4 b idle", 1'b1, 1'b0);
    b_en = 1'b1; step(1);
    check("R4 b start", 1'b1, 1'b1);
    step(2); check("R5 b hold", 1'b1, 1'b1);
    step(1); check("R5 b toggle", 1'b1, 1'b0);

    // R8 forcing codes
    wr_cfg(8'h5D);
    check("R8 force high", 1'b1, 1'b1);
    wr_cfg(8'h59);
    check("R8 force low", 1'b1, 1'b0);
    step(5); check("R8 enable ignored", 1'b1, 1'b0);
    b_en = 1'b0; step(1);

    // R6 alternating, A reload 2, B reload 1, B enable held high
    wr_a(8'd2); wr_b(16'd1);
    wr_cfg(8'h44);
    b_en = 1'b1; step(1);
    check("R6 idle", 1'b1, 1'b1);
    a_en = 1'b1; step(1);
    check("R6 a starts", 1'b0, 1'b1);
    step(2); check("R6 b waits", 1'b0, 1'b1);
    step(1); check("R6 handover to b", 1'b1, 1'b0);
    step(1); check("R6 a stopped", 1'b1, 1'b0);
    step(1); check("R6 b toggles", 1'b1, 1'b1);
    step(2); check("R6 a turn", 1'b1, 1'b1);
    step(1); check("R6 a toggles", 1'b0, 1'b1);
    step(2); check("R6 b toggles 2", 1'b0, 1'b0);

    // R7 normal code ends alternation
    wr_cfg(8'h40);
    step(3); check("R7 independent", 1'b1, 1'b1);
    a_en = 1'b0; b_en = 1'b0; step(1);

    // R10 receive mode parks timers
    wr_cfg(8'hC0);
    gpo = 1'b1; a_en = 1'b1; b_en = 1'b1;
    step(3); check("R10 parked gpo1", 1'b1, 1'b1);
    gpo = 1'b0; #1;
    check("R10 parked gpo0", 1'b1, 1'b1);

    // R2 pin select 0 while A runs
    b_en = 1'b0; gpo = 1'b1;
    wr_cfg(8'h00); step(1);
    check("R2 gpo while running", 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule